// File: doc/BRIEF.md
# Indexed RTC Control and Interrupt Register Port

This block sits between a byte-wide host access port and the time-keeping core of a real-time clock. The host reaches a 128-byte register space through two addresses. A write to the even address selects a byte. An access to the odd address reads or writes the selected byte. Most bytes are plain storage. Four fixed positions hold the clock's control and status registers: a rate/divider register, a mode and enable register, an interrupt flag register and a validity register.

The time counter and the alarm comparator live outside this block. They report periodic, alarm and update-ended events as one-cycle pulses, and the block turns those pulses into flags and a level interrupt. The block also counts sub-second ticks from a tick-enable input. From that count it produces the update-in-progress status near the end of each second and a one-cycle strobe when a second completes. The strobe is what drives the external time counter.

Top module: `rtc_index_port`

## Requirements
- R1: A write to the even address (acc_addr=0) loads the index with the low 7 data bits. A read of the even address returns 0xFF.
- R2: An odd-address access (acc_addr=1) writes or reads the byte at the current index in a 128-byte space. Read data appears on acc_rdata on the cycle after the read access.
- R3: The four control registers sit at fixed indices: A at 10, B at 11, C at 12 and D at 13. Writes to C and D are ignored, and D always reads 0x80. Bit 7 of A is the read-only update-in-progress bit and reflects live status whatever value is written. Bits 6:0 of A hold the written value.
- R4: A read of C returns IRQF (bit 7), PF (bit 6), AF (bit 5) and UF (bit 4), with bits 3:0 zero. The same read clears C and lowers irq_o on the following cycle.
- R5: A pulse on ev_periodic, ev_alarm or ev_update sets PF, AF or UF respectively. If that flag was clear and its enable bit in B is set, IRQF is set and irq_o is high on the next cycle. The enables are PIE (bit 6), AIE (bit 5) and UIE (bit 4). irq_o follows IRQF.
- R6: On a write to B, irq_o and IRQF rise on the next cycle if any newly written enable matches a flag already set in C. Otherwise IRQF is cleared and irq_o goes low.
- R7: A write to B with SET (bit 7) at 1 stores UIE as 0.
- R8: The clock runs only while SET is clear and A bits 6:4 are at most 2. The sub-second counter advances on tick_en only while the clock runs. A value in A with bits 6 and 5 both set is a divider reset. A write that moves A out of divider reset to a running rate, with SET clear, restarts the counter at half a second.
- R9: A bit 7 reads 1 while the clock runs and the counter is within the last UIP_TICKS ticks of the second. sec_strobe pulses for one cycle after the tick that completes a second.
- R10: With rst_n low at a clock edge, the block takes A=0x26, B=0x02, C=0x00 and index 0, lowers irq_o and clears the sub-second counter. D reads 0x80.
- R11: A plat_reset pulse clears PIE, AIE and SQWE (bit 3) in B, clears all of C and lowers irq_o. The other bits of B and all of A are kept.
- R12: When a read of C coincides with an event pulse, the read returns the value from before the event, and the event's flag stays set for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| plat_reset | input | 1 | Synchronous platform reset pulse; clears enables and flags |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index address, 1 = data address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read access |
| tick_en | input | 1 | Sub-second tick enable |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm-match event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| irq_o | output | 1 | Level interrupt request |
| sec_strobe | output | 1 | One-cycle pulse at each completed second |

## Verification
Every result of this block is due exactly one clock edge after its cause. Read data follows the read access, irq_o follows an event, a B write or a C read, and sec_strobe follows the completing tick. The update-in-progress bit is sampled at the access edge, so it reflects the ticks counted before that edge. The bench drives all inputs at falling edges. A monitor flop marks each read edge and pops the expected byte at the next falling edge, and irq_o and sec_strobe are checked at the falling edge right after the driving task returns. Tick bursts are counted exactly, which puts the sub-second counter at known values on both sides of the update-in-progress window.

// File: rtl/rtc_port_pkg.sv
// Package: register indices, bit positions and reset values shared by the
// indexed RTC port and its sub-blocks.
package rtc_port_pkg;
    localparam int BYTE_W = 8;

    // Fixed register positions in the indexed space
    localparam int REG_A_IDX = 10;
    localparam int REG_B_IDX = 11;
    localparam int REG_C_IDX = 12;
    localparam int REG_D_IDX = 13;

    // Register B bit positions
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;

    localparam logic [BYTE_W-1:0] REG_A_INIT = 8'h26;
    localparam logic [BYTE_W-1:0] REG_B_INIT = 8'h02;
    localparam logic [BYTE_W-1:0] REG_D_VAL  = 8'h80;
    localparam logic [BYTE_W-1:0] IDX_READ   = 8'hFF;
    // Enables dropped by a platform reset: PIE, AIE, SQWE
    localparam logic [BYTE_W-1:0] B_PLAT_CLR = 8'h68;

    // Event vector ordering {periodic, alarm, update} matches C bits 6:4
    typedef logic [2:0] evvec_t;
endpackage

// File: rtl/rtc_cmos_ram.sv
// Module: rtc_cmos_ram
// Plain byte storage for the indexed space. One write port, one
// combinational read port on the same address.
// Assumes: the caller gates writes to positions it implements elsewhere;
// contents are not reset.
module rtc_cmos_ram #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one byte on a gated write
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_uip_timer.sv
// Module: rtc_uip_timer
// Sub-second tick counter. Raises update-in-progress in the last
// UIP_TICKS ticks of each second and strobes when a second completes.
// Assumes: TICKS >= 2 and UIP_TICKS < TICKS; half_load only while stopped.
module rtc_uip_timer #(
    parameter int TICKS     = 32768,
    parameter int UIP_TICKS = 8,
    localparam int CW       = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    input  logic half_load,
    output logic uip,
    output logic sec_strobe
);
    localparam logic [CW-1:0] LAST      = CW'(TICKS - 1);
    localparam logic [CW-1:0] HALF      = CW'(TICKS / 2);
    localparam logic [CW-1:0] UIP_START = CW'(TICKS - UIP_TICKS);

    logic [CW-1:0] cnt_q;
    logic          sec_q;

    // Advance, wrap or half-second restart of the counter; strobe on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sec_q <= 1'b0;
        end else begin
            sec_q <= run && tick_en && (cnt_q == LAST);
            if (half_load)
                cnt_q <= HALF;
            else if (run && tick_en)
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    assign uip        = run && (cnt_q >= UIP_START);
    assign sec_strobe = sec_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !half_load) |=> $stable(cnt_q));
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q |=> !sec_q);
endmodule

// File: rtl/rtc_irq_flags.sv
// Module: rtc_irq_flags
// Interrupt flag register C and the level interrupt. Events set flags,
// a C read clears them, a B write re-evaluates the summary bit.
// Assumes: rd_clr and b_wr never occur in the same cycle.
module rtc_irq_flags
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  evvec_t            ev,
    input  evvec_t            en,
    input  logic              rd_clr,
    input  logic              b_wr,
    input  evvec_t            b_wen,
    output logic [BYTE_W-1:0] c_val,
    output logic              irq
);
    evvec_t flags_q;
    logic   irqf_q;
    evvec_t base;
    logic   raise;

    // New flag with its enable set asks for an interrupt
    always_comb begin
        base  = rd_clr ? '0 : flags_q;
        raise = |(ev & ~flags_q & en);
    end

    // Flag and summary update; platform reset wins, events survive a read
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            flags_q <= '0;
            irqf_q  <= 1'b0;
        end else begin
            flags_q <= base | ev;
            if (b_wr)
                irqf_q <= (|(b_wen & flags_q)) | raise;
            else
                irqf_q <= (rd_clr ? 1'b0 : irqf_q) | raise;
        end
    end

    assign c_val = {irqf_q, flags_q, 4'b0000};
    assign irq   = irqf_q;

    assert_rdclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev == '0) |=> (!irq && flags_q == '0));
    assert_ev_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !b_wr && |(ev & ~flags_q & en)) |=> irq);
    assert_bwr_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && !clr_all && |(b_wen & flags_q)) |=> irq);
    assert_bwr_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && !clr_all && !(|(b_wen & flags_q)) && !(|(ev & ~flags_q & en))) |=> !irq);
    assert_platclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!irq && flags_q == '0));
endmodule

// File: rtl/rtc_index_port.sv
// Module: rtc_index_port (top)
// Two-address index/data host port over a 128-byte space holding the RTC
// rate register A, mode register B, flag register C and validity byte D.
// Assumes: one host access per acc_en cycle; event inputs are one-cycle
// pulses from the external time core.
module rtc_index_port
    import rtc_port_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int TICKS     = 32768,
    parameter int UIP_TICKS = 8,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plat_reset,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_addr,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    input  logic              tick_en,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    output logic              irq_o,
    output logic              sec_strobe
);
    logic [IDX_W-1:0]  idx_q;
    logic [6:0]        a_q;
    logic [BYTE_W-1:0] b_q;
    logic [BYTE_W-1:0] b_wdata_eff;
    logic [BYTE_W-1:0] ram_rdata;
    logic [BYTE_W-1:0] c_val;
    logic [BYTE_W-1:0] rd_next;
    logic idx_wr, data_wr, data_rd, rd_cyc;
    logic sel_a, sel_b, sel_c, sel_d;
    logic run, half_load, uip;

    // Decode the access and the selected register
    always_comb begin
        rd_cyc  = acc_en && !acc_wr;
        idx_wr  = acc_en && acc_wr && !acc_addr;
        data_wr = acc_en && acc_wr && acc_addr;
        data_rd = rd_cyc && acc_addr;
        sel_a   = idx_q == IDX_W'(REG_A_IDX);
        sel_b   = idx_q == IDX_W'(REG_B_IDX);
        sel_c   = idx_q == IDX_W'(REG_C_IDX);
        sel_d   = idx_q == IDX_W'(REG_D_IDX);
    end

    // Clock-run and half-second restart conditions, SET masking of UIE
    always_comb begin
        run         = !b_q[B_SET] && (a_q[6:4] <= 3'd2);
        half_load   = data_wr && sel_a && (a_q[6:5] == 2'b11) &&
                      (acc_wdata[6:4] <= 3'd2) && !b_q[B_SET];
        b_wdata_eff = acc_wdata;
        if (acc_wdata[B_SET]) b_wdata_eff[B_UIE] = 1'b0;
    end

    // Index register load from the even address
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= acc_wdata[IDX_W-1:0];
    end

    // Register A: writable low bits; bit 7 is produced live
    always_ff @(posedge clk) begin
        if (!rst_n)                a_q <= REG_A_INIT[6:0];
        else if (data_wr && sel_a) a_q <= acc_wdata[6:0];
    end

    // Register B: platform reset drops enables, SET forces UIE off
    always_ff @(posedge clk) begin
        if (!rst_n)                b_q <= REG_B_INIT;
        else if (plat_reset)       b_q <= b_q & ~B_PLAT_CLR;
        else if (data_wr && sel_b) b_q <= b_wdata_eff;
    end

    rtc_cmos_ram #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (data_wr && !(sel_a || sel_b || sel_c || sel_d)),
        .addr  (idx_q),
        .wdata (acc_wdata),
        .rdata (ram_rdata)
    );

    rtc_uip_timer #(.TICKS(TICKS), .UIP_TICKS(UIP_TICKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick_en    (tick_en),
        .half_load  (half_load),
        .uip        (uip),
        .sec_strobe (sec_strobe)
    );

    rtc_irq_flags u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (plat_reset),
        .ev      ({ev_periodic, ev_alarm, ev_update}),
        .en      (b_q[B_PIE:B_UIE]),
        .rd_clr  (data_rd && sel_c),
        .b_wr    (data_wr && sel_b),
        .b_wen   (b_wdata_eff[B_PIE:B_UIE]),
        .c_val   (c_val),
        .irq     (irq_o)
    );

    // Read data selection
    always_comb begin
        rd_next = ram_rdata;
        if (!acc_addr)  rd_next = IDX_READ;
        else if (sel_a) rd_next = {uip, a_q};
        else if (sel_b) rd_next = b_q;
        else if (sel_c) rd_next = c_val;
        else if (sel_d) rd_next = REG_D_VAL;
    end

    // Registered read data, one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_rdata <= '0;
        else if (rd_cyc) acc_rdata <= rd_next;
    end

    assert_idx_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && !acc_addr) |=> (acc_rdata == IDX_READ));
    assert_set_uie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel_b && acc_wdata[B_SET] && !plat_reset) |=> !b_q[B_UIE]);
endmodule

// File: tb/tb_rtc_index_port.sv
`timescale 1ns/1ps
module tb_rtc_index_port;
    localparam int TICKS = 64;
    localparam int UIPT  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, plat_reset = 1'b0;
    logic acc_en = 1'b0, acc_wr = 1'b0, acc_addr = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic tick_en = 1'b0, ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
    logic irq_o, sec_strobe;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;  // 250 MHz

    rtc_index_port #(.TICKS(TICKS), .UIP_TICKS(UIPT)) dut (
        .clk(clk), .rst_n(rst_n), .plat_reset(plat_reset),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .tick_en(tick_en),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .irq_o(irq_o), .sec_strobe(sec_strobe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: marks each read edge, compares the popped item at the next falling edge
    always @(posedge clk) rd_seen <= acc_en && !acc_wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("unexpected read", acc_rdata, 8'hxx);
            else check(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
        end
    end

    task automatic acc(input logic wr, input logic addr, input logic [7:0] d);
        acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
        acc(1'b1, 1'b0, idx);
        acc(1'b1, 1'b1, d);
    endtask

    task automatic rd(input logic addr, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        acc(1'b0, addr, 8'h00);
    endtask

    task automatic rreg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        acc(1'b1, 1'b0, idx);
        rd(1'b1, exp, tag);
    endtask

    task automatic pulse(input logic [2:0] ev);
        {ev_periodic, ev_alarm, ev_update} = ev;
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: power-up state
        check("R10 irq after reset", {7'b0, irq_o}, 8'h00);
        rreg(8'd10, 8'h26, "R10 reg A");
        rreg(8'd11, 8'h02, "R10 reg B");
        rreg(8'd12, 8'h00, "R10 reg C");
        rreg(8'd13, 8'h80, "R10 reg D");
        // R1: index port
        rd(1'b0, 8'hFF, "R1 even read");
        acc(1'b1, 1'b0, 8'h8B);
        rd(1'b1, 8'h02, "R1 index masked to 7 bits");
        // R2: plain storage
        wreg(8'h40, 8'h5A);
        wreg(8'h7F, 8'hC3);
        wreg(8'h00, 8'h11);
        rreg(8'h40, 8'h5A, "R2 byte 0x40");
        rreg(8'h7F, 8'hC3, "R2 byte 0x7F");
        rreg(8'h00, 8'h11, "R2 byte 0x00");
        // R3: C and D ignore writes
        wreg(8'd12, 8'hFF);
        rreg(8'd12, 8'h00, "R3 C write ignored");
        wreg(8'd13, 8'h00);
        rreg(8'd13, 8'h80, "R3 D write ignored");
        // R5: flag without enable, then with enable
        pulse(3'b100);
        check("R5 no irq without enable", {7'b0, irq_o}, 8'h00);
        rreg(8'd12, 8'h40, "R5 PF flag");
        rd(1'b1, 8'h00, "R4 C cleared by read");
        wreg(8'd11, 8'h42);
        check("R6 no flag no irq", {7'b0, irq_o}, 8'h00);
        pulse(3'b100);
        check("R5 irq on enabled PF", {7'b0, irq_o}, 8'h01);
        rreg(8'd12, 8'hC0, "R4 C value with IRQF");
        check("R4 irq dropped after C read", {7'b0, irq_o}, 8'h00);
        // R6: enabling an already-set flag
        wreg(8'd11, 8'h02);
        pulse(3'b010);
        check("R6 AF alone no irq", {7'b0, irq_o}, 8'h00);
        wreg(8'd11, 8'h22);
        check("R6 enable on set flag raises", {7'b0, irq_o}, 8'h01);
        wreg(8'd11, 8'h02);
        check("R6 disable lowers", {7'b0, irq_o}, 8'h00);
        rreg(8'd12, 8'h20, "R6 IRQF cleared, AF kept");
        // R7: SET masks UIE
        wreg(8'd11, 8'h92);
        rreg(8'd11, 8'h82, "R7 UIE forced off");
        pulse(3'b001);
        check("R7 UF no irq under SET", {7'b0, irq_o}, 8'h00);
        rreg(8'd12, 8'h10, "R7 UF flag");
        wreg(8'd11, 8'h02);
        // R12: read of C coincides with an event
        pulse(3'b100);
        acc(1'b1, 1'b0, 8'd12);
        exp_q.push_back(8'h40); tag_q.push_back("R12 read returns old C");
        ev_alarm = 1'b1;
        acc(1'b0, 1'b1, 8'h00);
        ev_alarm = 1'b0;
        rd(1'b1, 8'h20, "R12 coincident AF kept");
        // R11: platform reset
        wreg(8'd11, 8'h7A);
        pulse(3'b010);
        check("R11 irq before platform reset", {7'b0, irq_o}, 8'h01);
        plat_reset = 1'b1;
        @(negedge clk);
        plat_reset = 1'b0;
        check("R11 irq lowered", {7'b0, irq_o}, 8'h00);
        rreg(8'd11, 8'h12, "R11 B enables cleared");
        rreg(8'd12, 8'h00, "R11 C cleared");
        rreg(8'd10, 8'h26, "R11 A kept");
        wreg(8'd11, 8'h02);
        // R8: divider reset and half-second restart
        wreg(8'd10, 8'h66);
        rreg(8'd10, 8'h66, "R8 divider reset value");
        ticks(100);
        wreg(8'd10, 8'h26);
        ticks(23);
        rreg(8'd10, 8'h26, "R9 UIP clear at count 55");
        ticks(1);
        rreg(8'd10, 8'hA6, "R9 UIP set at count 56");
        wreg(8'd10, 8'h27);
        rreg(8'd10, 8'hA7, "R3 UIP read-only on write");
        wreg(8'd10, 8'h26);
        ticks(7);
        check("R9 no strobe at 63", {7'b0, sec_strobe}, 8'h00);
        ticks(1);
        check("R9 strobe at wrap", {7'b0, sec_strobe}, 8'h01);
        @(negedge clk);
        check("R9 strobe one cycle", {7'b0, sec_strobe}, 8'h00);
        rreg(8'd10, 8'h26, "R9 counter wrapped");
        // R8: SET holds the counter
        wreg(8'd11, 8'h82);
        ticks(60);
        rreg(8'd10, 8'h26, "R8 stopped under SET");
        wreg(8'd11, 8'h02);
        ticks(56);
        rreg(8'd10, 8'hA6, "R8 counter held under SET");
        // R8: rate field above 2 stops the clock
        wreg(8'd10, 8'h36);
        ticks(10);
        rreg(8'd10, 8'h36, "R8 stopped by rate field");
        wreg(8'd10, 8'h26);
        rreg(8'd10, 8'hA6, "R8 counter held by rate field");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R2 reads outstanding", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule